// File: doc/BRIEF.md
# Calendar Seconds Counter with Rate Trim

This block keeps wall-clock time as a binary count of seconds. It runs from a slow reference clock (nominally 32.768 kHz). A prescaler divides that clock down to one tick per second, and each tick advances a 32-bit seconds register. A crystal that runs a little fast or slow can be corrected with a signed trim. The trim lengthens or shortens one second in every interval of 1 to 256 seconds, so the average rate can be set in steps far finer than one reference cycle per second.

Software reaches the block through a synchronous register port that runs on the reference clock. There are four word registers. The seconds register can be loaded only while counting is stopped. The trim register holds the trim value and the interval. The status register holds the run bit and an overflow flag. The protection register holds two bits: one freezes the trim register, the other freezes the protection register itself. A seconds value of zero means "time not valid", so the block never holds zero.

Top module: `sec_clock_core`

## Requirements
- R1: After reset, the seconds register reads 1 and the trim, status and protection registers read 0. Reads of the bits a register does not define return 0.
- R2: While running with a trim of 0, the seconds register advances by one every 2^PRE_W reference cycles. This is 32768 cycles at the default PRE_W = 15.
- R3: In a trimmed second, the period is 2^PRE_W minus the two's-complement trim held in trim register bits [7:0]. At PRE_W = 10: 0x01 gives 1023, 0x7F gives 897, 0xFF gives 1025 and 0x80 gives 1152.
- R4: Trim register bits [15:8] hold a field F. The trim applies only to the first second of each interval of F+1 seconds. The other seconds of the interval use the nominal period.
- R5: A new trim register value is held pending until the current interval ends. It then becomes active, and the next interval is counted from that boundary.
- R6: A write to address 0 (seconds) is accepted only while status bit 0 (run) is 0. An accepted write of 0 stores 1. An accepted write also restarts the prescaler from zero.
- R7: While status bit 0 is 0, the prescaler and the seconds register hold their values.
- R8: A tick at 0xFFFFFFFF loads 1 and sets status bit 1 (overflow). The overflow flag stays set until a write to address 2 with bit 1 set.
- R9: While protection register (address 3) bit 0 is 1, writes to the trim register (address 1) are ignored.
- R10: While protection register bit 1 is 1, writes to the protection register are ignored. Both of its bits then keep their values until reset.
- R11: Address map: 0 seconds, 1 trim, 2 status, 3 protection. Read data is a combinational function of the address and the register contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (32.768 kHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| we | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |

## Verification
The embedded assertions check a set of local rules on every cycle:
- the seconds value is never zero;
- the all-ones value wraps to 1 and sets the overflow flag;
- the seconds value and the prescaler hold while stopped;
- the prescaler returns to zero after each tick;
- the interval counter either steps by one or restarts at a boundary;
- a locked register never changes, and a seconds write while running has no effect.

Some behaviour only the bench scenarios can show:
- the exact length of each second under each trim value;
- which seconds of an interval receive the trim;
- the one-interval delay before a new trim setting takes effect.

The bench measures the gap between successive seconds changes and compares it against a model of the interval schedule.

// File: rtl/sec_clock_pkg.sv
package sec_clock_pkg;
    localparam int BUS_W = 32;

    typedef enum logic [1:0] {
        A_SECS = 2'd0,
        A_TRIM = 2'd1,
        A_STAT = 2'd2,
        A_PROT = 2'd3
    } sc_addr_e;
endpackage

// File: rtl/sc_prescaler.sv
module sc_prescaler #(
    parameter int PRE_W  = 15,
    parameter int TRIM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic              trim_on,
    input  logic [TRIM_W-1:0] trim,
    output logic              tick
);
    localparam int CNT_W = PRE_W + 1;
    localparam logic [CNT_W-1:0] NOMINAL = CNT_W'(1) << PRE_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [CNT_W-1:0] trim_ext;
    logic [CNT_W-1:0] period;

    always_comb begin
        trim_ext = {{(CNT_W-TRIM_W){trim[TRIM_W-1]}}, trim};
        period   = trim_on ? (NOMINAL - trim_ext) : NOMINAL;
        tick     = run && (s_q.cnt == period - CNT_W'(1));
        s_d      = s_q;
        if (restart) begin
            s_d.cnt = '0;
        end else if (run) begin
            s_d.cnt = tick ? '0 : s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> s_q.cnt == '0);
    // R7
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(s_q.cnt));
endmodule

// File: rtl/sc_trim_sched.sv
module sc_trim_sched #(
    parameter int TRIM_W = 8,
    parameter int IVL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [TRIM_W-1:0] pend_trim,
    input  logic [IVL_W-1:0]  pend_ivl,
    output logic              trim_on,
    output logic [TRIM_W-1:0] act_trim
);
    typedef struct packed {
        logic [IVL_W-1:0]  pos;
        logic [IVL_W-1:0]  ivl;
        logic [TRIM_W-1:0] trim;
    } sched_t;

    sched_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick) begin
            if (s_q.pos == s_q.ivl) begin
                s_d.pos  = '0;
                s_d.ivl  = pend_ivl;
                s_d.trim = pend_trim;
            end else begin
                s_d.pos = s_q.pos + IVL_W'(1);
            end
        end
    end

    assign trim_on  = (s_q.pos == '0);
    assign act_trim = s_q.trim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5
    boundary_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.pos == s_q.ivl) |=> s_q.pos == '0);
    // R4
    step_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.pos != s_q.ivl) |=> s_q.pos == $past(s_q.pos) + IVL_W'(1));
    // R5
    config_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(s_q.trim) && $stable(s_q.ivl) && $stable(s_q.pos)));
endmodule

// File: rtl/sc_seconds.sv
module sc_seconds #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [SEC_W-1:0] load_val,
    input  logic             ovf_clr,
    output logic [SEC_W-1:0] secs,
    output logic             ovf
);
    localparam logic [SEC_W-1:0] ONE = SEC_W'(1);

    typedef struct packed {
        logic [SEC_W-1:0] secs;
        logic             ovf;
    } sec_state_t;

    sec_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ovf_clr) s_d.ovf = 1'b0;
        if (load) begin
            s_d.secs = (load_val == '0) ? ONE : load_val;
        end else if (tick) begin
            if (&s_q.secs) begin
                s_d.secs = ONE;
                s_d.ovf  = 1'b1;
            end else begin
                s_d.secs = s_q.secs + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.secs <= ONE;
            s_q.ovf  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign secs = s_q.secs;
    assign ovf  = s_q.ovf;

    // R6
    never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        secs != '0);
    // R8
    wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && (&s_q.secs)) |=> (s_q.secs == ONE && s_q.ovf));
    // R7
    secs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(s_q.secs));
endmodule

// File: rtl/sec_clock_core.sv
module sec_clock_core
    import sec_clock_pkg::*;
#(
    parameter int PRE_W  = 15,
    parameter int SEC_W  = 32,
    parameter int TRIM_W = 8,
    parameter int IVL_W  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  addr,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);
    localparam int TRIM_LO = 0;
    localparam int IVL_LO  = TRIM_W;

    typedef struct packed {
        logic              run;
        logic [TRIM_W-1:0] trim;
        logic [IVL_W-1:0]  ivl;
        logic              lk_trim;
        logic              lk_prot;
    } ctl_t;

    ctl_t c_d, c_q;
    sc_addr_e a_c;
    logic sec_load, ovf_clr, tick, trim_on;
    logic [TRIM_W-1:0] act_trim;
    logic [SEC_W-1:0]  secs;
    logic              ovf;

    assign a_c = sc_addr_e'(addr);

    always_comb begin
        c_d      = c_q;
        sec_load = 1'b0;
        ovf_clr  = 1'b0;
        if (we) begin
            case (a_c)
                A_SECS: sec_load = !c_q.run;
                A_TRIM: if (!c_q.lk_trim) begin
                    c_d.trim = wdata[TRIM_LO +: TRIM_W];
                    c_d.ivl  = wdata[IVL_LO +: IVL_W];
                end
                A_STAT: begin
                    c_d.run = wdata[0];
                    ovf_clr = wdata[1];
                end
                A_PROT: if (!c_q.lk_prot) begin
                    c_d.lk_trim = wdata[0];
                    c_d.lk_prot = wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    sc_prescaler #(.PRE_W(PRE_W), .TRIM_W(TRIM_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(c_q.run), .restart(sec_load),
        .trim_on(trim_on), .trim(act_trim), .tick(tick)
    );

    sc_trim_sched #(.TRIM_W(TRIM_W), .IVL_W(IVL_W)) u_sched (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .pend_trim(c_q.trim), .pend_ivl(c_q.ivl),
        .trim_on(trim_on), .act_trim(act_trim)
    );

    sc_seconds #(.SEC_W(SEC_W)) u_secs (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(sec_load),
        .load_val(wdata[SEC_W-1:0]), .ovf_clr(ovf_clr),
        .secs(secs), .ovf(ovf)
    );

    always_comb begin
        rdata = '0;
        case (a_c)
            A_SECS: rdata[SEC_W-1:0] = secs;
            A_TRIM: begin
                rdata[TRIM_LO +: TRIM_W] = c_q.trim;
                rdata[IVL_LO +: IVL_W]   = c_q.ivl;
            end
            A_STAT: rdata[1:0] = {ovf, c_q.run};
            A_PROT: rdata[1:0] = {c_q.lk_prot, c_q.lk_trim};
            default: rdata = '0;
        endcase
    end

    // R9
    trim_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.lk_trim |=> ($stable(c_q.trim) && $stable(c_q.ivl)));
    // R10
    prot_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.lk_prot |=> (c_q.lk_prot && $stable(c_q.lk_trim)));
    // R6
    busy_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && a_c == A_SECS && c_q.run && !tick) |=> $stable(secs));
endmodule

// File: tb/tb_sec_clock_core.sv
module tb_sec_clock_core;
    localparam int PRE_W = 10;
    localparam int NOM   = 1 << PRE_W;

    typedef struct {
        int          period;
        logic [31:0] value;
        string       req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_fail = 0;
    longint cyc = 0;

    exp_t exp_q[$];
    bit mon_on = 1'b0;
    logic [31:0] mon_prev;
    longint mon_last;

    // model of the requirement-level state
    logic [31:0] m_sec = 32'd1;
    int m_pos = 0, m_ivl = 0, m_ivl_p = 0;
    logic [7:0] m_trim = 8'd0, m_trim_p = 8'd0;
    bit m_lk_trim = 1'b0;

    sec_clock_core #(.PRE_W(PRE_W)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we),
        .wdata(wdata), .rdata(rdata)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(posedge clk);
        #1;
        we = 1'b0; addr = 2'd0;
        if (a == 2'd1 && !m_lk_trim) begin
            m_trim_p = d[7:0];
            m_ivl_p  = int'(d[15:8]);
        end
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1;
        v = rdata;
    endtask

    function automatic int next_period();
        int p;
        int t;
        t = m_trim[7] ? int'(m_trim) - 256 : int'(m_trim);
        p = (m_pos == 0) ? NOM - t : NOM;
        if (m_pos == m_ivl) begin
            m_pos = 0; m_ivl = m_ivl_p; m_trim = m_trim_p;
        end else begin
            m_pos++;
        end
        return p;
    endfunction

    // driver: push the expected seconds, start counting, wait, stop
    task automatic run_secs(int n, string req);
        exp_t it;
        mon_prev = m_sec;
        for (int i = 0; i < n; i++) begin
            it.period = next_period();
            m_sec = (m_sec == 32'hFFFF_FFFF) ? 32'd1 : m_sec + 32'd1;
            it.value = m_sec;
            it.req = req;
            exp_q.push_back(it);
        end
        wr(2'd2, 32'd1);
        mon_last = cyc;
        mon_on = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        mon_on = 1'b0;
        wr(2'd2, 32'd0);
    endtask

    // monitor: time each change of the seconds value
    always @(negedge clk) begin
        if (mon_on && rdata != mon_prev) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected seconds change", rdata, mon_prev);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                chk(cyc - mon_last == it.period, it.req, "second length",
                    cyc - mon_last, it.period);
                chk(rdata == it.value, it.req, "seconds value", rdata, it.value);
            end
            mon_last = cyc;
            mon_prev = rdata;
        end
    end

    initial begin
        wait (cyc > 150000);
        chk(1'b0, "R2", "watchdog expired", cyc, 150000);
        finish_run();
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R11 map
        rd(2'd0, v); chk(v == 32'd1, "R1", "seconds after reset", v, 1);
        rd(2'd1, v); chk(v == 32'd0, "R1", "trim after reset", v, 0);
        rd(2'd2, v); chk(v == 32'd0, "R1", "status after reset", v, 0);
        rd(2'd3, v); chk(v == 32'd0, "R1", "protection after reset", v, 0);

        // R6 zero write forced to one, plain load
        wr(2'd0, 32'd0); m_sec = 32'd1;
        rd(2'd0, v); chk(v == 32'd1, "R6", "zero load", v, 1);
        wr(2'd0, 32'd5); m_sec = 32'd5;
        rd(2'd0, v); chk(v == 32'd5, "R6", "load 5", v, 5);

        // R2 nominal seconds
        run_secs(3, "R2");

        // R5: trim 0x01 waits for the boundary; R3: then 1023 cycles
        wr(2'd1, 32'h0000_0001);
        wr(2'd0, 32'd20); m_sec = 32'd20;
        run_secs(3, "R5");

        // R4: trim 0x7F (897 cycles) every third second
        wr(2'd1, 32'h0000_027F);
        wr(2'd0, 32'd40); m_sec = 32'd40;
        run_secs(6, "R4");

        // R3: trim 0x80 (1152) written mid-interval, R5 delay applies
        wr(2'd1, 32'h0000_0080);
        wr(2'd0, 32'd60); m_sec = 32'd60;
        run_secs(4, "R3");

        // R3: trim 0xFF (1025) every second second
        wr(2'd1, 32'h0000_01FF);
        wr(2'd0, 32'd80); m_sec = 32'd80;
        run_secs(5, "R3");

        // R11 unused trim bits read zero
        rd(2'd1, v); chk(v == 32'h0000_01FF, "R11", "trim readback", v, 32'h1FF);

        // R6 seconds write while running is ignored
        wr(2'd0, m_sec);
        wr(2'd2, 32'd1);
        wr(2'd0, 32'd99);
        rd(2'd0, v); chk(v == m_sec, "R6", "load while running", v, m_sec);
        wr(2'd2, 32'd0);

        // R7 stopped counter holds
        wr(2'd0, m_sec);
        wr(2'd2, 32'd1);
        repeat (300) @(negedge clk);
        wr(2'd2, 32'd0);
        rd(2'd0, v);
        repeat (2000) @(negedge clk);
        rd(2'd0, v2);
        chk(v2 == v, "R7", "seconds frozen", v2, v);
        chk(v == m_sec, "R7", "no tick in partial second", v, m_sec);

        // R8 wrap to one with overflow flag
        wr(2'd0, 32'hFFFF_FFFF); m_sec = 32'hFFFF_FFFF;
        run_secs(1, "R8");
        rd(2'd2, v); chk(v == 32'd2, "R8", "overflow flag set", v, 2);
        wr(2'd2, 32'd2);
        rd(2'd2, v); chk(v == 32'd0, "R8", "overflow flag cleared", v, 0);

        // R9 trim lock
        wr(2'd3, 32'd1); m_lk_trim = 1'b1;
        wr(2'd1, 32'h0000_0510);
        rd(2'd1, v); chk(v == 32'h0000_01FF, "R9", "locked trim write", v, 32'h1FF);
        wr(2'd3, 32'd0); m_lk_trim = 1'b0;
        rd(2'd3, v); chk(v == 32'd0, "R9", "trim lock cleared", v, 0);
        wr(2'd1, 32'h0000_0310);
        rd(2'd1, v); chk(v == 32'h0000_0310, "R9", "unlocked trim write", v, 32'h310);

        // R10 protection register locks itself
        wr(2'd3, 32'd3); m_lk_trim = 1'b1;
        wr(2'd3, 32'd0);
        rd(2'd3, v); chk(v == 32'd3, "R10", "protection sticky", v, 3);
        wr(2'd1, 32'h0000_0000);
        rd(2'd1, v); chk(v == 32'h0000_0310, "R10", "trim still locked", v, 32'h310);

        finish_run();
    end
endmodule